// File: doc/BRIEF.md
# I2C Target Register Front-End with Alternate Addresses

This block is the write path from an I2C bus into the register bank of an LED engine. It samples SCL and SDA with the system clock, detects START, repeated START and STOP, and shifts in each byte on the rising edge of SCL. It drives SDA only as an open-drain pull-down, to acknowledge. A transfer is accepted when its 7-bit address equals the value on the hardware strap pins, or equals one of four addresses held in the register bank: one all-call and three sub-call. Each of these four has its own enable bit.

After an accepted address, the first data byte sets a register pointer. Each following byte is written to a shadow copy of the register that the pointer selects, and the pointer then advances. A control bit chooses when shadow data reaches the active registers that drive the engine. With the bit clear, every register is copied at STOP. With the bit set, each byte is copied as it is acknowledged.

A write to the general-call address followed by the reset code 0x06 produces a one-cycle reset pulse. The same pulse returns every register to its default value.

Top module: `i2c_tgt_frontend`

## Requirements
- R1: After reset, SDA is released and the registers hold their defaults: register 0 = 0x02, registers 1..4 = 0x70, 0x71, 0x72, 0x73, all others 0x00.
- R2: A write address (R/W bit 0) equal to the strap pins is acknowledged. The acknowledge pulls SDA low during the ninth SCL clock, and SDA only changes while the synchronised SCL is low. An address with the R/W bit set to 1 is never acknowledged.
- R3: Registers 1..4 hold the all-call address and sub-call addresses 1..3 in bits 6:0. Register 0 bits 1..4 enable them in that order. A disabled address is not acknowledged.
- R4: With register 0 bit 0 clear, written bytes reach the active registers only at STOP. A repeated START does not commit them.
- R5: The first data byte after an accepted address loads the register pointer. Each further byte is written at the pointer, and the pointer then advances, wrapping from NUM_REGS-1 to 0.
- R6: With register 0 bit 0 set, each written byte is visible on the register outputs by the end of its acknowledge clock, with no STOP needed.
- R7: A STOP or repeated START in the middle of a byte discards that byte. No register changes because of it.
- R8: After an address that is not acknowledged, the target acknowledges nothing and writes nothing until the next START.
- R9: The general-call address 0x00 is acknowledged. A following byte 0x06 is acknowledged and gives one one-cycle reset pulse, and all registers return to their defaults. Any other following byte is not acknowledged and causes no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| sdaOe | output | 1 | 1 pulls SDA low (open-drain) |
| addrPins | input | 7 | Strapped target address |
| regsOut | output | NUM_REGS*8 | Active registers, register i in bits 8i+7:8i |
| swResetPulse | output | 1 | One-cycle pulse on a general-call reset |

## Verification
Two full sweeps drive all 128 write addresses, first with the default enables and then with the all-call disabled and the three sub-calls enabled. Together the sweeps separate strap matching, the enable gating and general-call acceptance from false matches. Writes are made in both commit modes, once across a repeated START and once with a pointer that wraps. These writes separate commit at STOP from commit per byte, and show that the pointer advances as required. Truncated bytes, non-matching and read addresses, and general-call bytes with and without the reset code show that nothing is written without a complete, accepted byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int CTRL_IDX    = 0;
  localparam int ALLCALL_IDX = 1;
  localparam int NUM_ALT     = 4;
  localparam logic [7:0] RESET_CODE = 8'h06;

  typedef struct packed {
    logic shift;
    logic loadPtr;
    logic write;
    logic commitAll;
    logic swReset;
  } strobe_t;

  function automatic logic [7:0] regDefault(int idx);
    if (idx == CTRL_IDX) return 8'h02;
    if (idx >= ALLCALL_IDX && idx < ALLCALL_IDX + NUM_ALT)
      return 8'h70 + 8'(idx - ALLCALL_IDX);
    return 8'h00;
  endfunction
endpackage

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclRise,
  input  logic    sclFall,
  input  logic    startDet,
  input  logic    stopDet,
  input  logic    addrHit,
  input  logic    genCallHit,
  input  logic    resetCodeHit,
  output strobe_t strb,
  output logic    sdaOe
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_DEC, ST_ACK, ST_DATA, ST_DATA_DEC, ST_IGNORE
  } state_t;

  state_t     stateQ, stateD;
  logic [2:0] bitCntQ, bitCntD;
  logic       ptrLoadedQ, ptrLoadedD;
  logic       genCallQ, genCallD;
  logic       sdaOeQ, sdaOeD;

  always_comb begin
    stateD     = stateQ;
    bitCntD    = bitCntQ;
    ptrLoadedD = ptrLoadedQ;
    genCallD   = genCallQ;
    sdaOeD     = sdaOeQ;
    strb       = '0;
    if (stopDet) begin
      strb.commitAll = 1'b1;
      stateD         = ST_IDLE;
      sdaOeD         = 1'b0;
    end else if (startDet) begin
      stateD  = ST_ADDR;
      bitCntD = '0;
      sdaOeD  = 1'b0;
    end else begin
      unique case (stateQ)
        ST_ADDR, ST_DATA: begin
          if (sclRise) begin
            strb.shift = 1'b1;
            bitCntD    = bitCntQ + 3'd1;
            if (bitCntQ == 3'd7)
              stateD = (stateQ == ST_ADDR) ? ST_ADDR_DEC : ST_DATA_DEC;
          end
        end
        ST_ADDR_DEC: begin
          if (sclFall) begin
            if (addrHit || genCallHit) begin
              sdaOeD     = 1'b1;
              genCallD   = genCallHit;
              ptrLoadedD = 1'b0;
              stateD     = ST_ACK;
            end else begin
              stateD = ST_IGNORE;
            end
          end
        end
        ST_DATA_DEC: begin
          if (sclFall) begin
            if (genCallQ) begin
              if (resetCodeHit) begin
                strb.swReset = 1'b1;
                sdaOeD       = 1'b1;
                stateD       = ST_ACK;
              end else begin
                stateD = ST_IGNORE;
              end
            end else begin
              if (!ptrLoadedQ) begin
                strb.loadPtr = 1'b1;
                ptrLoadedD   = 1'b1;
              end else begin
                strb.write = 1'b1;
              end
              sdaOeD = 1'b1;
              stateD = ST_ACK;
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            sdaOeD  = 1'b0;
            bitCntD = '0;
            stateD  = ST_DATA;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      bitCntQ    <= '0;
      ptrLoadedQ <= 1'b0;
      genCallQ   <= 1'b0;
      sdaOeQ     <= 1'b0;
    end else begin
      stateQ     <= stateD;
      bitCntQ    <= bitCntD;
      ptrLoadedQ <= ptrLoadedD;
      genCallQ   <= genCallD;
      sdaOeQ     <= sdaOeD;
    end
  end

  assign sdaOe = sdaOeQ;
endmodule

// File: rtl/i2c_tgt_datapath.sv
module i2c_tgt_datapath
  import i2c_tgt_pkg::*;
#(
  parameter int NUM_REGS = 8,
  localparam int PTR_W   = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strb,
  input  logic                  sdaBit,
  input  logic [6:0]            addrPins,
  output logic                  addrHit,
  output logic                  genCallHit,
  output logic                  resetCodeHit,
  output logic [NUM_REGS*8-1:0] regsOut
);
  logic [7:0]       rxByte;
  logic [PTR_W-1:0] ptrQ;
  logic             ackMode;
  logic             altHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxByte <= '0;
    else if (strb.shift) rxByte <= {rxByte[6:0], sdaBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ptrQ <= '0;
    else if (strb.loadPtr) ptrQ <= rxByte[PTR_W-1:0];
    else if (strb.write) ptrQ <= ptrQ + 1'b1;
  end

  assign ackMode = regsOut[CTRL_IDX*8];

  always_comb begin
    altHit = 1'b0;
    for (int k = 0; k < NUM_ALT; k++) begin
      if (regsOut[CTRL_IDX*8 + 1 + k] &&
          rxByte[7:1] == regsOut[(ALLCALL_IDX + k)*8 +: 7])
        altHit = 1'b1;
    end
  end

  assign addrHit      = !rxByte[0] && (rxByte[7:1] == addrPins || altHit);
  assign genCallHit   = (rxByte == 8'h00);
  assign resetCodeHit = (rxByte == RESET_CODE);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [7:0] shadowQ, activeQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shadowQ <= regDefault(i);
        activeQ <= regDefault(i);
      end else if (strb.swReset) begin
        shadowQ <= regDefault(i);
        activeQ <= regDefault(i);
      end else if (strb.write && ptrQ == PTR_W'(i)) begin
        shadowQ <= rxByte;
        if (ackMode) activeQ <= rxByte;
      end else if (strb.commitAll) begin
        activeQ <= shadowQ;
      end
    end
    assign regsOut[i*8 +: 8] = activeQ;
  end
endmodule

// File: rtl/i2c_tgt_frontend.sv
module i2c_tgt_frontend
  import i2c_tgt_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOe,
  input  logic [6:0]            addrPins,
  output logic [NUM_REGS*8-1:0] regsOut,
  output logic                  swResetPulse
);
  logic    sclMeta, sclS, sclPrev;
  logic    sdaMeta, sdaS, sdaPrev;
  logic    sclRise, sclFall, startDet, stopDet;
  logic    addrHit, genCallHit, resetCodeHit;
  strobe_t strb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {sclMeta, sclS, sclPrev} <= 3'b111;
      {sdaMeta, sdaS, sdaPrev} <= 3'b111;
    end else begin
      {sclMeta, sclS, sclPrev} <= {sclIn, sclMeta, sclS};
      {sdaMeta, sdaS, sdaPrev} <= {sdaIn, sdaMeta, sdaS};
    end
  end

  assign sclRise  = sclS && !sclPrev;
  assign sclFall  = !sclS && sclPrev;
  assign startDet = sclS && sclPrev && sdaPrev && !sdaS;
  assign stopDet  = sclS && sclPrev && !sdaPrev && sdaS;

  i2c_tgt_ctrl u_ctrl (
    .clk, .rstN, .sclRise, .sclFall, .startDet, .stopDet,
    .addrHit, .genCallHit, .resetCodeHit, .strb, .sdaOe
  );

  i2c_tgt_datapath #(.NUM_REGS(NUM_REGS)) u_dp (
    .clk, .rstN, .strb, .sdaBit(sdaS), .addrPins,
    .addrHit, .genCallHit, .resetCodeHit, .regsOut
  );

  assign swResetPulse = strb.swReset;
endmodule

// File: rtl/i2c_tgt_checker.sv
module i2c_tgt_checker
  import i2c_tgt_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sclS,
  input logic                  sdaOe,
  input strobe_t               strb,
  input logic [NUM_REGS*8-1:0] regsOut,
  input logic                  swResetPulse
);
  logic [NUM_REGS*8-1:0] defImage;
  always_comb
    for (int i = 0; i < NUM_REGS; i++) defImage[i*8 +: 8] = regDefault(i);

  a_r2_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaOe) || $fell(sdaOe)) |-> !sclS);

  a_r4_regs_hold_without_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.write && !strb.commitAll && !strb.swReset) |=> $stable(regsOut));

  a_r9_reset_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    swResetPulse |=> !swResetPulse);

  a_r9_reset_restores_defaults: assert property (@(posedge clk) disable iff (!rstN)
    swResetPulse |=> (regsOut == defImage));

  a_r7_no_write_with_commit: assert property (@(posedge clk) disable iff (!rstN)
    strb.write |-> !strb.commitAll && !strb.swReset);
endmodule

bind i2c_tgt_frontend i2c_tgt_checker #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk, .rstN, .sclS, .sdaOe, .strb, .regsOut, .swResetPulse
);

// File: tb/sim_i2c_tgt_frontend.sv
module sim_i2c_tgt_frontend;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam int NREG = 8;
  localparam logic [6:0] PINS = 7'h2A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaOe, swResetPulse, sdaLine;
  logic [NREG*8-1:0] regsOut;
  int total = 0, bad = 0, pulses = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sdaLine = sdaM & ~sdaOe;

  i2c_tgt_frontend #(.NUM_REGS(NREG)) u0 (
    .clk, .rstN, .sclIn(sclM), .sdaIn(sdaLine), .sdaOe,
    .addrPins(PINS), .regsOut, .swResetPulse
  );

  always @(posedge clk) if (swResetPulse) pulses++;

  function automatic logic [7:0] defVal(int i);
    if (i == 0) return 8'h02;
    if (i >= 1 && i <= 4) return 8'h70 + 8'(i - 1);
    return 8'h00;
  endfunction

  task automatic waitQ(int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic i2cStart;
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic i2cStop;
    sdaM = 1'b0; waitQ(); sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ(2);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i]; waitQ(); sclM = 1'b1; waitQ(2); sclM = 1'b0; waitQ();
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    sendBits(b, 8);
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ();
    ack = !sdaLine;
    waitQ(); sclM = 1'b0; waitQ();
  endtask

  function automatic logic [7:0] reg8(int i);
    return regsOut[i*8 +: 8];
  endfunction

  task automatic finishRun;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic sweep(input logic [7:0] enMask);
    logic ack;
    for (int a = 0; a < 128; a++) begin
      logic expAck;
      i2cStart(); sendByte({7'(a), 1'b0}, ack); i2cStop();
      expAck = (7'(a) == PINS) || (a == 0);
      for (int k = 0; k < 4; k++)
        if (enMask[1+k] && a == 8'h70 + k) expAck = 1'b1;
      check(expAck && 7'(a) == PINS ? "R2" : "R3", 32'(ack), 32'(expAck));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    finishRun();
  end

  initial begin
    logic ack;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    waitQ();
    // R1: reset state
    check("R1 sdaOe", 32'(sdaOe), 0);
    for (int i = 0; i < NREG; i++) check("R1 default", 32'(reg8(i)), 32'(defVal(i)));

    // R2/R3: sweep with defaults (all-call only)
    sweep(8'h02);
    i2cStart(); sendByte({PINS, 1'b1}, ack); i2cStop();
    check("R2 read nack", 32'(ack), 0);

    // R4: stop-mode commit across a repeated START
    i2cStart(); sendByte({PINS, 1'b0}, ack); sendByte(8'h05, ack); sendByte(8'h11, ack);
    i2cStart(); sendByte({PINS, 1'b0}, ack); sendByte(8'h06, ack); sendByte(8'h22, ack);
    check("R4 pending reg5", 32'(reg8(5)), 0);
    check("R4 pending reg6", 32'(reg8(6)), 0);
    i2cStop();
    check("R4 commit reg5", 32'(reg8(5)), 32'h11);
    check("R4 commit reg6", 32'(reg8(6)), 32'h22);

    // R5: pointer wrap 7 -> 0, enabling sub-calls and disabling all-call
    i2cStart(); sendByte({PINS, 1'b0}, ack); sendByte(8'h07, ack);
    sendByte(8'h33, ack); sendByte(8'h1C, ack); i2cStop();
    check("R5 reg7", 32'(reg8(7)), 32'h33);
    check("R5 wrap reg0", 32'(reg8(0)), 32'h1C);

    // R3: sweep with sub-calls enabled
    sweep(8'h1C);

    // R7: partial byte then STOP
    i2cStart(); sendByte({PINS, 1'b0}, ack); sendByte(8'h06, ack);
    sendBits(8'hFF, 4); i2cStop();
    check("R7 stop mid-byte", 32'(reg8(6)), 32'h22);
    // R7: partial byte then repeated START
    i2cStart(); sendByte({PINS, 1'b0}, ack); sendByte(8'h06, ack); sendBits(8'hEE, 5);
    i2cStart(); sendByte({PINS, 1'b0}, ack); sendByte(8'h07, ack); sendByte(8'h55, ack);
    i2cStop();
    check("R7 Sr mid-byte reg6", 32'(reg8(6)), 32'h22);
    check("R7 Sr next write reg7", 32'(reg8(7)), 32'h55);

    // R8: unmatched address, bytes after it ignored
    i2cStart(); sendByte(8'h2A, ack);
    check("R8 addr nack", 32'(ack), 0);
    sendByte(8'h03, ack); check("R8 data nack", 32'(ack), 0);
    sendByte(8'h99, ack); check("R8 data nack", 32'(ack), 0);
    i2cStop();
    check("R8 reg3 kept", 32'(reg8(3)), 32'h72);

    // R6: per-byte commit, addressed via sub-call 1
    i2cStart(); sendByte({PINS, 1'b0}, ack); sendByte(8'h00, ack); sendByte(8'h1D, ack);
    i2cStop();
    i2cStart(); sendByte(8'hE2, ack);
    check("R6 sub1 ack", 32'(ack), 1);
    sendByte(8'h05, ack); sendByte(8'h44, ack);
    check("R6 reg5 before stop", 32'(reg8(5)), 32'h44);
    sendByte(8'h45, ack);
    check("R6 reg6 before stop", 32'(reg8(6)), 32'h45);
    i2cStop();

    // R9: general call with a wrong code, then the reset code
    i2cStart(); sendByte(8'h00, ack);
    check("R9 gencall ack", 32'(ack), 1);
    sendByte(8'h07, ack); i2cStop();
    check("R9 wrong code nack", 32'(ack), 0);
    check("R9 no pulse", 32'(pulses), 0);
    check("R9 regs kept", 32'(reg8(5)), 32'h44);
    i2cStart(); sendByte(8'h00, ack); sendByte(8'h06, ack); i2cStop();
    check("R9 code ack", 32'(ack), 1);
    check("R9 one pulse", 32'(pulses), 1);
    for (int i = 0; i < NREG; i++) check("R9 default", 32'(reg8(i)), 32'(defVal(i)));

    finishRun();
  end
endmodule